// File: doc/BRIEF.md
# Flag-Setting ALU with Operand Shifter

This block is the purely combinational data-processing stage of a 32-bit load/store RISC core. The second operand first passes through a barrel shifter, which can shift it left or right (logically or arithmetically), rotate it, or rotate it by one place through the carry flag. The shifted value then goes to either an adder/subtractor or a bitwise logic unit. The block returns a result word, a result write-enable, and new values for the four condition flags: negative, zero, carry and overflow.

The caller provides the current carry and overflow flags. The carry-including arithmetic operations and the rotate-through-carry shift use the incoming carry. Logical operations pass the incoming overflow flag straight through. Compare and test operations compute the same values as their arithmetic or logical counterparts, but they lower the write-enable so that only the flags are committed.

Top module: `alu_shift_core`

## Requirements
- R1: With `op_sel` encoded as AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15, the operations ADD, ADC, SUB and SBC return a+s, a+s+C, a-s and a-s-(1-C) modulo 2^32. Here s is the shifted second operand and C is `flag_c_in`.
- R2: RSB returns s-a, and RSC returns s-a-(1-C).
- R3: AND, ORR, EOR, BIC, MOV and MVN return a&s, a|s, a^s, a&~s, s and ~s.
- R4: With `shift_kind` encoded as LSL=0, LSR=1, ASR=2, ROR=3, RRX=4, a nonzero `shift_amt` shifts or rotates operand b by that many places. For a logical operation, the carry flag becomes the last bit shifted out. For ROR this is bit 31 of the rotated result.
- R5: A `shift_amt` of zero with a kind other than RRX leaves operand b unchanged. For a logical operation it also leaves the carry flag equal to `flag_c_in`.
- R6: RRX ignores `shift_amt`. It shifts operand b right by one, puts `flag_c_in` into bit 31, and for a logical operation sets the carry flag to the old bit 0.
- R7: `flag_n` equals result bit 31, and `flag_z` is 1 exactly when the whole 32-bit result is zero.
- R8: For arithmetic operations, `flag_c` is the adder carry-out. For subtractions this means no borrow occurred (the minuend is greater than or equal to the subtrahend, unsigned, when the borrow-in is clear).
- R9: For arithmetic operations, `flag_v` flags signed overflow. For logical operations, `flag_v` equals `flag_v_in`.
- R10: CMP, CMN, TST and TEQ drive `wr_en` low. Their result and flags are those of SUB, ADD, AND and EOR respectively. All other operations drive `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, fed through the shifter |
| op_sel | input | 4 | Operation code |
| shift_kind | input | 3 | Shift type applied to opnd_b |
| shift_amt | input | 5 | Shift distance, 0 to 31 |
| flag_c_in | input | 1 | Current carry flag |
| flag_v_in | input | 1 | Current overflow flag |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Result should be written back |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The embedded assertions are immediate checks on settled combinational values. They assume that every input is a known 0/1 value and that `shift_kind` holds one of the five defined codes. The bench changes all inputs together at one clock edge and observes the outputs only half a period later. It uses only the five defined shift codes, and it drives every input from the first cycle onward, so that no check ever sees an undefined or half-updated operand.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [3:0] {
      OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
      OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
      OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
      OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
   } op_e;

   typedef enum logic [2:0] {
      SH_LSL = 3'd0, SH_LSR = 3'd1, SH_ASR = 3'd2, SH_ROR = 3'd3, SH_RRX = 3'd4
   } shk_e;

   function automatic logic op_is_arith(input logic [3:0] op);
      return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
   endfunction

   function automatic logic op_flags_only(input logic [3:0] op);
      return op[3:2] == 2'b10;
   endfunction
endpackage

// File: rtl/alu_barrel_shift.sv
module alu_barrel_shift #(
   parameter int W   = 32,
   parameter int SHW = $clog2(W)
) (
   input  logic [W-1:0]   b_i,
   input  logic [2:0]     kind_i,
   input  logic [SHW-1:0] amt_i,
   input  logic           cin_i,
   output logic [W-1:0]   res_o,
   output logic           cout_o
);
   import alu_pkg::*;

   logic [W:0]     wide_l;
   logic [W:0]     wide_r;
   logic [W:0]     wide_a;
   logic [2*W-1:0] dbl;

   always_comb begin
      wide_l = {1'b0, b_i} << amt_i;
      wide_r = {b_i, 1'b0} >> amt_i;
      wide_a = $signed({b_i, 1'b0}) >>> amt_i;
      dbl    = {b_i, b_i} >> amt_i;
      res_o  = b_i;
      cout_o = cin_i;
      if (kind_i == SH_RRX) begin
         res_o  = {cin_i, b_i[W-1:1]};
         cout_o = b_i[0];
      end else if (amt_i != '0) begin
         case (kind_i)
            SH_LSL: begin res_o = wide_l[W-1:0]; cout_o = wide_l[W]; end
            SH_LSR: begin res_o = wide_r[W:1];   cout_o = wide_r[0]; end
            SH_ASR: begin res_o = wide_a[W:1];   cout_o = wide_a[0]; end
            SH_ROR: begin res_o = dbl[W-1:0];    cout_o = dbl[W-1];  end
            default: begin res_o = b_i;          cout_o = cin_i;     end
         endcase
      end
   end

   always_comb begin
      if (kind_i == SH_ROR) begin
         // R4
         rot_pop_chk: assert ($countones(res_o) == $countones(b_i))
            else $error("rotate changed population count");
      end
      if (kind_i == SH_LSL || kind_i == SH_LSR) begin
         // R4
         shift_pop_chk: assert ($countones(res_o) <= $countones(b_i))
            else $error("logical shift created ones");
      end
   end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o
);
   if (RIPPLE) begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = cin_i;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum_o[i]  = x_i[i] ^ y_i[i] ^ cy[i];
         assign cy[i+1]   = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
      end
      assign cout_o = cy[W];
      assign ovf_o  = cy[W] ^ cy[W-1];
   end else begin : g_behav
      logic [W:0] tot;
      assign tot    = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
      assign sum_o  = tot[W-1:0];
      assign cout_o = tot[W];
      assign ovf_o  = (x_i[W-1] == y_i[W-1]) && (tot[W-1] != x_i[W-1]);
   end

   always_comb begin
      // R9
      ovf_sign_chk: assert (!ovf_o || (x_i[W-1] == y_i[W-1]))
         else $error("overflow with operands of unlike sign");
      if (!cin_i) begin
         // R8
         carry_wrap_chk: assert (cout_o == (sum_o < x_i))
            else $error("carry does not match wrap-around");
      end
   end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
   parameter int W = 32
) (
   input  logic [3:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] s_i,
   output logic [W-1:0] res_o
);
   import alu_pkg::*;

   always_comb begin
      case (op_i)
         OP_AND, OP_TST: res_o = a_i & s_i;
         OP_EOR, OP_TEQ: res_o = a_i ^ s_i;
         OP_ORR:         res_o = a_i | s_i;
         OP_BIC:         res_o = a_i & ~s_i;
         OP_MOV:         res_o = s_i;
         OP_MVN:         res_o = ~s_i;
         default:        res_o = '0;
      endcase
   end
endmodule

// File: rtl/alu_shift_core.sv
module alu_shift_core #(
   parameter int W          = 32,
   parameter bit RIPPLE_ADD = 1'b0,
   localparam int SHW       = $clog2(W)
) (
   input  logic [31:0] opnd_a,
   input  logic [31:0] opnd_b,
   input  logic [3:0]  op_sel,
   input  logic [2:0]  shift_kind,
   input  logic [4:0]  shift_amt,
   input  logic        flag_c_in,
   input  logic        flag_v_in,
   output logic [31:0] result,
   output logic        wr_en,
   output logic        flag_n,
   output logic        flag_z,
   output logic        flag_c,
   output logic        flag_v
);
   import alu_pkg::*;

   if (W != 32) begin : g_bad_width
      $error("alu_shift_core: port widths are fixed at 32 bits");
   end
   if (SHW != 5) begin : g_bad_shw
      $error("alu_shift_core: shift amount width must be 5");
   end

   logic [W-1:0] s_val;
   logic         sh_c;
   logic [W-1:0] add_x, add_y, add_sum, log_res;
   logic         add_ci, add_co, add_ov;
   logic         arith;

   alu_barrel_shift #(.W(W), .SHW(SHW)) shift_i (
      .b_i(opnd_b), .kind_i(shift_kind), .amt_i(shift_amt),
      .cin_i(flag_c_in), .res_o(s_val), .cout_o(sh_c)
   );

   always_comb begin
      add_x  = opnd_a;
      add_y  = s_val;
      add_ci = 1'b0;
      case (op_sel)
         OP_ADD, OP_CMN: add_ci = 1'b0;
         OP_ADC:         add_ci = flag_c_in;
         OP_SUB, OP_CMP: begin add_y = ~s_val; add_ci = 1'b1; end
         OP_SBC:         begin add_y = ~s_val; add_ci = flag_c_in; end
         OP_RSB:         begin add_x = s_val; add_y = ~opnd_a; add_ci = 1'b1; end
         OP_RSC:         begin add_x = s_val; add_y = ~opnd_a; add_ci = flag_c_in; end
         default:        add_ci = 1'b0;
      endcase
   end

   alu_adder #(.W(W), .RIPPLE(RIPPLE_ADD)) add_i (
      .x_i(add_x), .y_i(add_y), .cin_i(add_ci),
      .sum_o(add_sum), .cout_o(add_co), .ovf_o(add_ov)
   );

   alu_logic_unit #(.W(W)) logic_i (
      .op_i(op_sel), .a_i(opnd_a), .s_i(s_val), .res_o(log_res)
   );

   assign arith  = op_is_arith(op_sel);
   assign result = arith ? add_sum : log_res;
   assign wr_en  = !op_flags_only(op_sel);
   assign flag_n = result[W-1];
   assign flag_z = (result == '0);
   assign flag_c = arith ? add_co : sh_c;
   assign flag_v = arith ? add_ov : flag_v_in;

   always_comb begin
      // R7
      nz_excl_chk: assert (!(flag_n && flag_z))
         else $error("negative and zero both set");
      if (!arith) begin
         // R9
         v_keep_chk: assert (flag_v == flag_v_in)
            else $error("logical op altered overflow");
      end
      if (!arith && shift_amt == '0 && shift_kind != SH_RRX) begin
         // R5
         zero_amt_c_chk: assert (flag_c == flag_c_in && result == log_res)
            else $error("zero shift altered carry");
      end
      if (op_sel == OP_MOV && shift_kind == SH_RRX) begin
         // R6
         rrx_top_chk: assert (result[W-1] == flag_c_in)
            else $error("rrx top bit not the old carry");
      end
   end
endmodule

// File: tb/alu_shift_core_tb.sv
module alu_shift_core_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [31:0] opnd_a = '0, opnd_b = '0, result;
   logic [3:0]  op_sel = '0;
   logic [2:0]  shift_kind = '0;
   logic [4:0]  shift_amt = '0;
   logic        flag_c_in = 1'b0, flag_v_in = 1'b0;
   logic        wr_en, flag_n, flag_z, flag_c, flag_v;

   alu_shift_core dut_i (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .shift_kind(shift_kind),
      .shift_amt(shift_amt), .flag_c_in(flag_c_in), .flag_v_in(flag_v_in),
      .result(result), .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic [3:0]  op;
      logic [2:0]  sk;
      logic [4:0]  amt;
      logic [31:0] a;
      logic [31:0] b;
      logic        ci;
      logic        vi;
      logic [31:0] res;
      logic [3:0]  nzcv;
      logic        we;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VECS [NV] = '{
      '{4'd4,  3'd0, 5'd0, 32'h1,        32'h2,        1'b0, 1'b0, 32'h3,        4'b0000, 1'b1},
      '{4'd4,  3'd0, 5'd0, 32'h7FFFFFFF, 32'h1,        1'b0, 1'b0, 32'h80000000, 4'b1001, 1'b1},
      '{4'd4,  3'd0, 5'd0, 32'hFFFFFFFF, 32'h1,        1'b0, 1'b0, 32'h0,        4'b0110, 1'b1},
      '{4'd5,  3'd0, 5'd0, 32'h5,        32'h3,        1'b1, 1'b0, 32'h9,        4'b0000, 1'b1},
      '{4'd2,  3'd0, 5'd0, 32'h5,        32'h3,        1'b0, 1'b0, 32'h2,        4'b0010, 1'b1},
      '{4'd2,  3'd0, 5'd0, 32'h3,        32'h5,        1'b0, 1'b0, 32'hFFFFFFFE, 4'b1000, 1'b1},
      '{4'd6,  3'd0, 5'd0, 32'h5,        32'h3,        1'b0, 1'b0, 32'h1,        4'b0010, 1'b1},
      '{4'd3,  3'd0, 5'd0, 32'h3,        32'hA,        1'b0, 1'b0, 32'h7,        4'b0010, 1'b1},
      '{4'd7,  3'd0, 5'd0, 32'h3,        32'hA,        1'b0, 1'b0, 32'h6,        4'b0010, 1'b1},
      '{4'd2,  3'd0, 5'd0, 32'h80000000, 32'h1,        1'b0, 1'b0, 32'h7FFFFFFF, 4'b0011, 1'b1},
      '{4'd0,  3'd0, 5'd0, 32'h0000F0F0, 32'h0000FF00, 1'b1, 1'b1, 32'h0000F000, 4'b0011, 1'b1},
      '{4'd14, 3'd0, 5'd0, 32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 1'b0, 32'hFFFF0000, 4'b1000, 1'b1},
      '{4'd1,  3'd0, 5'd0, 32'hAAAAAAAA, 32'hAAAAAAAA, 1'b0, 1'b0, 32'h0,        4'b0100, 1'b1},
      '{4'd12, 3'd0, 5'd0, 32'h12340000, 32'h00005678, 1'b0, 1'b0, 32'h12345678, 4'b0000, 1'b1},
      '{4'd15, 3'd0, 5'd0, 32'h0,        32'h0,        1'b0, 1'b0, 32'hFFFFFFFF, 4'b1000, 1'b1},
      '{4'd13, 3'd0, 5'd4, 32'h0,        32'hF0000001, 1'b0, 1'b0, 32'h00000010, 4'b0010, 1'b1},
      '{4'd13, 3'd1, 5'd1, 32'h0,        32'h00000003, 1'b0, 1'b0, 32'h00000001, 4'b0010, 1'b1},
      '{4'd13, 3'd2, 5'd4, 32'h0,        32'h80000008, 1'b0, 1'b0, 32'hF8000000, 4'b1010, 1'b1},
      '{4'd13, 3'd3, 5'd8, 32'h0,        32'h000000A5, 1'b0, 1'b0, 32'hA5000000, 4'b1010, 1'b1},
      '{4'd13, 3'd4, 5'd7, 32'h0,        32'h00000002, 1'b1, 1'b0, 32'h80000001, 4'b1000, 1'b1},
      '{4'd13, 3'd0, 5'd0, 32'h0,        32'h12345678, 1'b1, 1'b0, 32'h12345678, 4'b0010, 1'b1},
      '{4'd10, 3'd0, 5'd0, 32'h5,        32'h5,        1'b0, 1'b0, 32'h0,        4'b0110, 1'b0},
      '{4'd8,  3'd0, 5'd0, 32'h000000F0, 32'h0000000F, 1'b0, 1'b1, 32'h0,        4'b0101, 1'b0},
      '{4'd11, 3'd0, 5'd0, 32'hFFFFFFFF, 32'h1,        1'b0, 1'b0, 32'h0,        4'b0110, 1'b0},
      '{4'd9,  3'd0, 5'd0, 32'h1,        32'h1,        1'b0, 1'b0, 32'h0,        4'b0100, 1'b0},
      '{4'd4,  3'd0, 5'd2, 32'h1,        32'h1,        1'b0, 1'b0, 32'h5,        4'b0000, 1'b1}
   };

   function automatic string tag_of(input logic [3:0] op, input logic [2:0] sk,
                                    input logic [4:0] amt);
      if (op[3:2] == 2'b10) return "R10";
      if (op == 4'd3 || op == 4'd7) return "R2";
      if (op >= 4'd2 && op <= 4'd7) return "R1";
      if (sk == 3'd4) return "R6";
      if (op == 4'd13 && amt == 5'd0) return "R5";
      if (op == 4'd13) return "R4";
      return "R3";
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(posedge clk);
      op_sel = v.op; shift_kind = v.sk; shift_amt = v.amt;
      opnd_a = v.a; opnd_b = v.b; flag_c_in = v.ci; flag_v_in = v.vi;
      @(negedge clk);
   endtask

   initial begin : watchdog
      for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      vec_t v;
      logic [31:0] pat, e;
      logic ec;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // idle inputs (AND of zeros): R7 zero flag, R10 write enable high
      check("R7 idle", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'b0100);
      check("R10 idle", {31'd0, wr_en}, 32'd1);

      for (int i = 0; i < NV; i++) begin
         v = VECS[i];
         drive(v);
         check(tag_of(v.op, v.sk, v.amt), result, v.res);
         check("R7/R8/R9 flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, v.nzcv});
         check("R10 wr_en", {31'd0, wr_en}, {31'd0, v.we});
      end

      // R4 sweep: LSR and ASR, every nonzero amount, bit-by-bit model
      pat = 32'h9E3779B9;
      for (int k = 1; k < 2; k++) begin
         for (int amt = 1; amt < 32; amt++) begin
            for (int kind = 1; kind <= 2; kind++) begin
               v = '{4'd13, 3'(kind), 5'(amt), 32'h0, pat, 1'b0, 1'b1,
                     32'h0, 4'b0000, 1'b1};
               drive(v);
               for (int bi = 0; bi < 32; bi++)
                  e[bi] = (bi + amt < 32) ? pat[bi + amt] : (kind == 2 ? pat[31] : 1'b0);
               ec = pat[amt - 1];
               check("R4 sweep result", result, e);
               check("R4 sweep carry", {31'd0, flag_c}, {31'd0, ec});
            end
         end
      end

      // R6: RRX with carry clear and shift_amt nonzero is ignored
      v = '{4'd13, 3'd4, 5'd31, 32'h0, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0, 4'b0000, 1'b1};
      drive(v);
      check("R6 rrx no carry", result, 32'h7FFFFFFF);
      check("R6 rrx carry out", {31'd0, flag_c}, 32'd1);

      // R8: SBC with carry set behaves as plain subtract, equal operands
      v = '{4'd6, 3'd0, 5'd0, 32'h9, 32'h9, 1'b1, 1'b0, 32'h0, 4'b0000, 1'b1};
      drive(v);
      check("R8 sbc equal", {result[3:0], flag_z, flag_c}, {4'h0, 1'b1, 1'b1});

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule